// File: doc/BRIEF.md
# Serial ADC Interface Responder

This block is the device-side framing logic of a two-channel, 10-bit sampling converter's serial port. A host lowers an active-low select, toggles a serial clock and sends bits on a data-in line. The block skips any leading zeros and treats the first one as the start of a frame. It then takes a mode bit and a polarity bit, ignores one dummy bit, and drives a channel selection toward the analog front end. It pulses a sample request when the selection is known and a conversion start when the sample window closes. The result it shifts back is ten bits, MSB first, after two zero bits. Once the result is out, zeros follow for as long as the host keeps clocking.

All logic runs on one fast system clock. The select, serial clock and data-in inputs are first passed through a synchronizer, and the block then acts on the detected serial-clock edges. Data-out changes after a falling serial-clock edge, so the host can sample it on the rising edge. The conversion result arrives on a parallel port with a one-cycle valid strobe. When the host deselects after it has taken the last result bit, a power-down flag rises and stays high until the next frame begins.

The frame state machine has eight states. IDLE means the host has deselected. HUNT waits for the start bit. CFG takes the mode and polarity bits. DUMMY waits for the dummy bit. HOLD waits for the falling edge that closes the sample window. NULL drives the zero bits. DATA shifts the result. PAD drives zeros.

The transitions are:
- IDLE→HUNT when select goes low.
- HUNT→CFG on a rising edge with data-in at one.
- CFG→DUMMY on the rising edge that takes the polarity bit.
- DUMMY→HOLD on the next rising edge.
- HOLD→NULL on the next falling edge.
- NULL→DATA on the falling edge after the last zero bit.
- DATA→PAD on the falling edge after the last result bit.
- Any state→IDLE whenever select goes high.

Top module: `sadc_responder`

## Requirements
- R1: While reset is held, dout_en, dout, samp_req, conv_start, pwr_dn, ain_pos, ain_neg and ain_neg_gnd are all 0.
- R2: While cs_n is low, rising serial-clock edges that see din=0 before the first din=1 are skipped. The first rising edge that sees din=1 is rising edge 1 of the frame. All later numbering counts from it.
- R3: Rising edge 2 captures the mode bit and rising edge 3 captures the polarity bit. The channel outputs stay 0 until edge 3 and then take the decoded value. Bit 0 of ain_pos and ain_neg is channel 0 and bit 1 is channel 1.
  - Mode 1, polarity 0: ain_pos=01, ain_neg=00, ain_neg_gnd=1.
  - Mode 1, polarity 1: ain_pos=10, ain_neg=00, ain_neg_gnd=1.
  - Mode 0, polarity 0: ain_pos=01, ain_neg=10, ain_neg_gnd=0.
  - Mode 0, polarity 1: ain_pos=10, ain_neg=01, ain_neg_gnd=0.
- R4: From rising edge 4 on, din has no effect for the rest of the frame. The channel outputs hold their value and the data-out sequence is unchanged whatever din does.
- R5: samp_req is a single-cycle pulse that comes after rising edge 3, while the serial clock is still high. conv_start is a single-cycle pulse that comes after the falling edge that follows rising edge 4. Each pulses exactly once per frame.
- R6: dout_en goes to 1 after the falling edge that follows rising edge 4, so the host first sees it at rising edge 5. It is 0 before that and within four system cycles after cs_n goes high.
- R7: At rising edges 5 and 6 dout is 0. At rising edges 7 through 16 dout carries B9 down to B0 of the latched result. The result is latched when res_vld is high after samp_req and before the falling edge that launches B9. If no such strobe arrives, the result is all zeros.
- R8: At every rising edge after edge 16 of the same frame, dout is 0.
- R9: A res_vld strobe after B9 has been launched leaves the result being shifted unchanged.
- R10: pwr_dn goes to 1 when cs_n rises after rising edge 16 of the frame. If cs_n rises earlier, pwr_dn stays 0. pwr_dn returns to 0 once cs_n goes low for the next frame.
- R11: Raising cs_n in the middle of a frame clears the channel outputs and dout_en. The next frame then runs the full sequence normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| res_data | input | RES_W | Parallel conversion result |
| res_vld | input | 1 | One-cycle strobe qualifying res_data |
| dout | output | 1 | Serial data to the host |
| dout_en | output | 1 | Drive enable for dout (0 = high impedance) |
| samp_req | output | 1 | Pulse: selection known, start sampling |
| conv_start | output | 1 | Pulse: sample window closed, start conversion |
| ain_pos | output | 2 | One-hot channel tied to the positive input |
| ain_neg | output | 2 | One-hot channel tied to the negative input |
| ain_neg_gnd | output | 1 | Negative input tied to ground |
| pwr_dn | output | 1 | Power-down indication after a complete frame |

## Verification
Every input edge passes through two synchronizer stages and one register, so each registered output moves three system cycles after the serial-clock or select edge that causes it. The bench holds each serial-clock phase for four system cycles and reads dout and dout_en in the cycle just before it raises the serial clock, which is where a host would sample. The two pulses last only one cycle, so a monitor counts them and records the rising-edge number and serial-clock level in force when each appears. Channel outputs, pwr_dn and the cleared state after deselect are read four cycles after the edge that should have updated them.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HUNT,
        S_CFG,
        S_DUMMY,
        S_HOLD,
        S_NULL,
        S_DATA,
        S_PAD
    } frame_state_e;

endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_act,
    output logic cs_rise,
    output logic cs_fall,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din_s
);
    localparam int W = 3;
    localparam logic [W-1:0] RST_VAL = 3'b100;

    logic [W*STAGES-1:0] chain;
    logic [W-1:0]        tap;
    logic                cs_prev;
    logic                sclk_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= {cs_n, sclk, din};
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[W*(STAGES-1)-1:0], cs_n, sclk, din};
            end
        end
    endgenerate

    assign tap = chain[W*STAGES-1 -: W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= tap[2];
            sclk_prev <= tap[1];
        end
    end

    assign cs_act    = ~tap[2];
    assign cs_rise   = tap[2] & ~cs_prev;
    assign cs_fall   = ~tap[2] & cs_prev;
    assign sclk_rise = tap[1] & ~sclk_prev;
    assign sclk_fall = ~tap[1] & sclk_prev;
    assign din_s     = tap[0];

endmodule

// File: rtl/sadc_frame_fsm.sv
module sadc_frame_fsm
    import sadc_pkg::*;
#(
    parameter int NULL_BITS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_act,
    input  logic         cs_rise,
    input  logic         cs_fall,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         din_s,
    input  logic         last_bit,
    output frame_state_e state,
    output logic         cfg_vld,
    output logic         cfg_sgl,
    output logic         cfg_odd,
    output logic         samp_req,
    output logic         conv_start,
    output logic         dout_en,
    output logic         load_msb,
    output logic         shift,
    output logic         pwr_dn
);
    localparam int NW = (NULL_BITS > 1) ? $clog2(NULL_BITS) : 1;
    localparam logic [NW-1:0] NULL_LAST = NW'(NULL_BITS - 1);

    frame_state_e   nxt;
    logic           cfg_cnt;
    logic [NW-1:0]  null_cnt;
    logic           b0_done;

    always_comb begin
        nxt      = state;
        load_msb = 1'b0;
        shift    = 1'b0;
        if (!cs_act) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_HUNT;
                S_HUNT:  if (sclk_rise && din_s) nxt = S_CFG;
                S_CFG:   if (sclk_rise && cfg_cnt) nxt = S_DUMMY;
                S_DUMMY: if (sclk_rise) nxt = S_HOLD;
                S_HOLD:  if (sclk_fall) nxt = S_NULL;
                S_NULL: begin
                    if (sclk_fall && null_cnt == NULL_LAST) begin
                        nxt      = S_DATA;
                        load_msb = 1'b1;
                    end
                end
                S_DATA: begin
                    if (sclk_fall) begin
                        shift = 1'b1;
                        if (last_bit) nxt = S_PAD;
                    end
                end
                S_PAD:   nxt = S_PAD;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_vld    <= 1'b0;
            cfg_sgl    <= 1'b0;
            cfg_odd    <= 1'b0;
            cfg_cnt    <= 1'b0;
            null_cnt   <= '0;
            samp_req   <= 1'b0;
            conv_start <= 1'b0;
            dout_en    <= 1'b0;
            b0_done    <= 1'b0;
            pwr_dn     <= 1'b0;
        end else begin
            samp_req   <= 1'b0;
            conv_start <= 1'b0;
            if (!cs_act) begin
                cfg_vld  <= 1'b0;
                cfg_sgl  <= 1'b0;
                cfg_odd  <= 1'b0;
                cfg_cnt  <= 1'b0;
                null_cnt <= '0;
                dout_en  <= 1'b0;
            end else begin
                if (state == S_CFG && sclk_rise) begin
                    if (!cfg_cnt) begin
                        cfg_sgl <= din_s;
                        cfg_cnt <= 1'b1;
                    end else begin
                        cfg_odd  <= din_s;
                        cfg_vld  <= 1'b1;
                        samp_req <= 1'b1;
                    end
                end
                if (state == S_HOLD && sclk_fall) begin
                    conv_start <= 1'b1;
                    dout_en    <= 1'b1;
                end
                if (state == S_NULL && sclk_fall && null_cnt != NULL_LAST)
                    null_cnt <= null_cnt + 1'b1;
                if (state == S_DATA && sclk_rise && last_bit)
                    b0_done <= 1'b1;
            end
            if (cs_fall) begin
                b0_done <= 1'b0;
                pwr_dn  <= 1'b0;
            end else if (cs_rise && b0_done) begin
                pwr_dn <= 1'b1;
            end
        end
    end

    AST_OE_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !dout_en); // R6
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        samp_req |=> !samp_req && !conv_start); // R5
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({samp_req, conv_start})); // R5
    AST_PWRDN_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_dn) |-> !cs_act); // R10
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_vld |=> (!cfg_vld || ($stable(cfg_sgl) && $stable(cfg_odd)))); // R4

endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_act,
    input  logic             res_win,
    input  logic             res_vld,
    input  logic [RES_W-1:0] res_data,
    input  logic             load_msb,
    input  logic             shift,
    output logic             dout,
    output logic             last_bit
);
    localparam int IW = (RES_W > 1) ? $clog2(RES_W) : 1;

    logic [RES_W-1:0] res_q;
    logic [IW-1:0]    idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            idx   <= '0;
            dout  <= 1'b0;
        end else if (!frame_act) begin
            res_q <= '0;
            idx   <= '0;
            dout  <= 1'b0;
        end else begin
            if (res_win && res_vld) res_q <= res_data;
            if (load_msb) begin
                dout <= res_q[RES_W-1];
                idx  <= IW'(RES_W - 1);
            end else if (shift) begin
                if (idx == '0) begin
                    dout <= 1'b0;
                end else begin
                    dout <= res_q[idx - IW'(1)];
                    idx  <= idx - IW'(1);
                end
            end
        end
    end

    assign last_bit = (idx == '0);

    AST_IDX_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_act && shift && !load_msb && idx != '0) |=> (idx == $past(idx) - IW'(1))); // R7

endmodule

// File: rtl/sadc_mux_dec.sv
module sadc_mux_dec (
    input  logic       cfg_vld,
    input  logic       cfg_sgl,
    input  logic       cfg_odd,
    output logic [1:0] ain_pos,
    output logic [1:0] ain_neg,
    output logic       ain_neg_gnd
);
    always_comb begin
        ain_pos     = 2'b00;
        ain_neg     = 2'b00;
        ain_neg_gnd = 1'b0;
        if (cfg_vld) begin
            ain_pos = cfg_odd ? 2'b10 : 2'b01;
            if (cfg_sgl) ain_neg_gnd = 1'b1;
            else         ain_neg = cfg_odd ? 2'b01 : 2'b10;
        end
    end
endmodule

// File: rtl/sadc_responder.sv
module sadc_responder
    import sadc_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int NULL_BITS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_vld,
    output logic             dout,
    output logic             dout_en,
    output logic             samp_req,
    output logic             conv_start,
    output logic [1:0]       ain_pos,
    output logic [1:0]       ain_neg,
    output logic             ain_neg_gnd,
    output logic             pwr_dn
);
    logic         cs_act, cs_rise, cs_fall, sclk_rise, sclk_fall, din_s;
    logic         last_bit, load_msb, shift;
    logic         cfg_vld, cfg_sgl, cfg_odd;
    logic         res_win;
    frame_state_e state;

    sadc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .cs_act(cs_act), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_s(din_s)
    );

    sadc_frame_fsm #(.NULL_BITS(NULL_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .cs_rise(cs_rise),
        .cs_fall(cs_fall), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .din_s(din_s), .last_bit(last_bit), .state(state),
        .cfg_vld(cfg_vld), .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd),
        .samp_req(samp_req), .conv_start(conv_start), .dout_en(dout_en),
        .load_msb(load_msb), .shift(shift), .pwr_dn(pwr_dn)
    );

    assign res_win = (state == S_DUMMY) || (state == S_HOLD) || (state == S_NULL);

    sadc_shifter #(.RES_W(RES_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .frame_act(cs_act), .res_win(res_win),
        .res_vld(res_vld), .res_data(res_data), .load_msb(load_msb),
        .shift(shift), .dout(dout), .last_bit(last_bit)
    );

    sadc_mux_dec u_dec (
        .cfg_vld(cfg_vld), .cfg_sgl(cfg_sgl), .cfg_odd(cfg_odd),
        .ain_pos(ain_pos), .ain_neg(ain_neg), .ain_neg_gnd(ain_neg_gnd)
    );

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAD) |-> !dout); // R8
    AST_MUX_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        ((ain_pos & ain_neg) == 2'b00) && !(ain_neg_gnd && (ain_neg != 2'b00))); // R3
    AST_NO_DRIVE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HUNT || state == S_CFG) |-> !dout_en); // R6

endmodule

// File: tb/tb_sadc_responder.sv
`timescale 1ns/1ps
module tb_sadc_responder;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic [9:0] res_data = '0;
    logic       res_vld = 1'b0;
    logic       dout, dout_en, samp_req, conv_start, ain_neg_gnd, pwr_dn;
    logic [1:0] ain_pos, ain_neg;

    int n_chk = 0, n_err = 0;
    int rises = 0;
    int n_samp = 0, samp_rise = 0, n_conv = 0, conv_rise = 0;
    logic samp_lvl = 1'b0, conv_lvl = 1'b0;
    logic host_dout, host_en;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sadc_responder dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .res_data(res_data), .res_vld(res_vld), .dout(dout), .dout_en(dout_en),
        .samp_req(samp_req), .conv_start(conv_start), .ain_pos(ain_pos),
        .ain_neg(ain_neg), .ain_neg_gnd(ain_neg_gnd), .pwr_dn(pwr_dn)
    );

    always @(posedge clk) begin
        if (samp_req) begin n_samp++; samp_rise = rises; samp_lvl = sclk; end
        if (conv_start) begin n_conv++; conv_rise = rises; conv_lvl = sclk; end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clk_bit(input logic d);
        @(negedge clk);
        din = d;
        host_dout = dout;
        host_en = dout_en;
        sclk = 1'b1;
        rises++;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic strobe(input logic [9:0] v);
        @(negedge clk);
        res_data = v;
        res_vld = 1'b1;
        @(negedge clk);
        res_vld = 1'b0;
    endtask

    task automatic frame(input int lead, input bit sgl, input bit odd,
                         input logic [9:0] val, input int vld_at,
                         input logic [9:0] late_val, input int late_at,
                         input int total);
        logic [9:0] exp_data;
        int s0, c0, e_pos, e_neg;
        exp_data = (vld_at > 0) ? val : 10'd0;
        e_pos = odd ? 2 : 1;
        e_neg = sgl ? 0 : (odd ? 1 : 2);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        chk("R10", "pwr_dn cleared on select", pwr_dn, 0);
        s0 = n_samp;
        c0 = n_conv;
        for (int i = 0; i < lead; i++) clk_bit(1'b0);
        rises = 0;
        clk_bit(1'b1);
        clk_bit(sgl);
        chk("R3", "ain_pos before edge 3", ain_pos, 0);
        chk("R2", "no early sample request", n_samp - s0, 0);
        clk_bit(odd);
        chk("R3", "ain_pos", ain_pos, e_pos);
        chk("R3", "ain_neg", ain_neg, e_neg);
        chk("R3", "ain_neg_gnd", ain_neg_gnd, sgl);
        chk("R5", "samp_req count", n_samp - s0, 1);
        chk("R5", "samp_req edge", samp_rise, 3);
        chk("R5", "samp_req sclk level", samp_lvl, 1);
        for (int k = 4; k <= total; k++) begin
            int e;
            if (k == vld_at) strobe(val);
            if (k == late_at) strobe(late_val);
            clk_bit(k[0] ^ k[1]);
            e = (k >= 7 && k <= 16) ? exp_data[16 - k] : 0;
            chk("R6", "dout_en at rise", host_en, (k >= 5) ? 1 : 0);
            if (k > 16) chk("R8", "pad dout", host_dout, 0);
            else if (late_at > 0) chk("R9", "dout with late strobe", host_dout, e);
            else chk("R7", "dout", host_dout, e);
        end
        chk("R5", "conv_start count", n_conv - c0, 1);
        chk("R5", "conv_start edge", conv_rise, 4);
        chk("R5", "conv_start sclk level", conv_lvl, 0);
        chk("R4", "ain_pos held", ain_pos, e_pos);
        chk("R4", "ain_neg held", ain_neg, e_neg);
        @(negedge clk);
        cs_n = 1'b1;
        din = 1'b0;
        repeat (H) @(negedge clk);
        chk("R6", "dout_en after deselect", dout_en, 0);
        chk("R10", "pwr_dn after deselect", pwr_dn, (total >= 16) ? 1 : 0);
        chk("R11", "ain_pos after deselect", ain_pos, 0);
        repeat (H) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk("R1", "dout_en", dout_en, 0);
        chk("R1", "dout", dout, 0);
        chk("R1", "pulses", {samp_req, conv_start}, 0);
        chk("R1", "pwr_dn", pwr_dn, 0);
        chk("R1", "mux", {ain_pos, ain_neg, ain_neg_gnd}, 0);
        rst_n = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic t_single_ch0();    frame(0, 1'b1, 1'b0, 10'h2A5, 5, 10'h0, 0, 16); endtask
    task automatic t_lead_zeros_pad(); frame(3, 1'b1, 1'b1, 10'h3FF, 5, 10'h0, 0, 22); endtask
    task automatic t_diff_ch0();      frame(1, 1'b0, 1'b0, 10'h155, 6, 10'h0, 0, 20); endtask
    task automatic t_diff_late();     frame(2, 1'b0, 1'b1, 10'h201, 5, 10'h0F0, 10, 18); endtask
    task automatic t_no_result();     frame(0, 1'b1, 1'b1, 10'h0, 0, 10'h0, 0, 16); endtask
    task automatic t_abort_recover();
        frame(0, 1'b0, 1'b1, 10'h3A3, 5, 10'h0, 0, 12);
        frame(1, 1'b1, 1'b0, 10'h0C3, 5, 10'h0, 0, 16);
    endtask

    initial begin
        t_reset();
        t_single_ch0();
        t_lead_zeros_pad();
        t_diff_ch0();
        t_diff_late();
        t_no_result();
        t_abort_recover();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule